// File: doc/BRIEF.md
# Serial Modem Configuration Register Port

This block holds the configuration word of a line modem and gives a host access to it over a synchronous bit-serial link. The link runs only while the register-select input is high and the synchronous access mode is in force. During an access the block drives its own serial clock from the system clock, through a programmable divider. The state of the direction input at the start of the access chooses between writing and reading. Written bits are taken MSB first on each rising edge of the serial clock. Read bits are presented MSB first and are stable at each rising edge.

The stored word has 48 bits, but only its low 24 bits are normally in play. An extended-mode bit inside the word raises the write length to 48 bits. A second bit, honoured only in extended mode, raises the read length to 48 bits. A write takes effect only when the exact required number of bits has been clocked in before the select line falls. The block decodes the line rate, the frequency deviation and the watchdog enable from the stored word and drives them as plain outputs.

The serial link is bit-serial with a clock the block owns, so there is no valid/ready pairing: the host paces itself from the serial clock, and back-pressure cannot arise. All pins are plain control, status or serial data pins.

Top module: `modem_cfg_port`

## Requirements
- R1: After reset `cfg_word` equals 48'h50, which decodes to 2400 baud, a deviation of half the baud rate and the watchdog enabled. `sclk` and `rx_bit` are low.
- R2: `sclk` toggles only while `reg_sel` is high and `async_mode` is low. Its period is 2*DIV_HALF system clocks, and it rests low when no access is running.
- R3: An access that starts with `rx_tx` low is a write. `tx_bit` is sampled at each rising edge of `sclk`, MSB first. When extended mode is off (bit 21 = 0), exactly 24 sampled bits commit to bits 23:0 on the fall of `reg_sel`, and bits 47:24 keep their value.
- R4: When bit 21 of the stored word is 1, a write commits only after exactly 48 bits, and then it replaces all 48 bits. A 24-bit write is then discarded.
- R5: A write with any other bit count, fewer or more, leaves `cfg_word` unchanged.
- R6: An access that starts with `rx_tx` high is a read. `rx_bit` carries the stored bits MSB first and is stable at each rising edge of `sclk`. The read length is 24 bits (bits 23:0), and `rx_bit` is 0 after the last bit and whenever no read is running.
- R7: A read returns all 48 bits, MSB first, only when both bit 21 and bit 18 are 1. With bit 21 set and bit 18 clear, the read stays at 24 bits.
- R8: While `async_mode` is high, `reg_sel` is ignored: no `sclk` edge occurs and `cfg_word` does not change.
- R9: Bits 4:3 hold the baud code (00=600, 01=1200, 10=2400, 11=4800), and `baud_rate` shows that value. Bit 5 set makes `dev_hz` equal to the baud rate; bit 5 clear makes it half the baud rate. Bit 6 drives `wdog_en`.
- R10: The direction is captured when the access starts, and later changes of `rx_tx` during that access have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| async_mode | input | 1 | High selects asynchronous access, which locks out the register |
| reg_sel | input | 1 | High requests register access |
| rx_tx | input | 1 | Direction at access start: 0 write, 1 read |
| tx_bit | input | 1 | Serial write data |
| sclk | output | 1 | Serial clock driven by the block |
| rx_bit | output | 1 | Serial read data |
| cfg_word | output | 48 | Stored configuration word |
| baud_code | output | 2 | Decoded baud code |
| baud_rate | output | 13 | Decoded line rate in baud |
| dev_hz | output | 13 | Decoded mark/space deviation in Hz |
| wdog_en | output | 1 | Watchdog enable field |
| ext_en | output | 1 | Extended-mode field (bit 21) |
| long_rd | output | 1 | Long-read field (bit 18) |

## Verification
The bench builds the block with DIV_HALF = 3, so one serial bit lasts six system clocks. At that speed a full 48-bit extended write and read-back costs only a few hundred cycles. The bench can then cover every baud code and every deviation setting, enter and leave extended mode, and send writes that are one bit short or one bit long. The period check measures the six-cycle bit time directly at the `sclk` pin.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  localparam int NORM_LEN  = 24;
  localparam int EXT_LEN   = 48;
  localparam int RATE_W    = 13;
  localparam int BAUD_LSB  = 3;
  localparam int DEV_BIT   = 5;
  localparam int WDOG_BIT  = 6;
  localparam int LONG_BIT  = 18;
  localparam int EXT_BIT   = 21;
  localparam int CNT_W     = $clog2(EXT_LEN + 2);
  localparam logic [EXT_LEN-1:0] RESET_WORD = 48'h0000_0000_0050;
  localparam logic [RATE_W-1:0]  BASE_RATE  = 13'd600;

  typedef struct packed {
    logic [1:0]        baud_code;
    logic [RATE_W-1:0] baud_rate;
    logic [RATE_W-1:0] dev_hz;
    logic              wdog_en;
    logic              ext_en;
    logic              long_rd;
  } cfg_fields_t;

  function automatic cfg_fields_t decode_cfg(input logic [EXT_LEN-1:0] w);
    cfg_fields_t f;
    f.baud_code = w[BAUD_LSB +: 2];
    f.baud_rate = BASE_RATE << f.baud_code;
    f.dev_hz    = w[DEV_BIT] ? f.baud_rate : (f.baud_rate >> 1);
    f.wdog_en   = w[WDOG_BIT];
    f.ext_en    = w[EXT_BIT];
    f.long_rd   = w[LONG_BIT];
    return f;
  endfunction
endpackage

// File: rtl/mcp_sclk_gen.sv
module mcp_sclk_gen #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DW-1:0] TERM = DW'(DIV_HALF - 1);

  logic [DW-1:0] div_q;
  logic          sclk_q;
  logic          term;

  assign term     = (div_q == TERM);
  assign rise_evt = active & term & ~sclk_q;
  assign fall_evt = active & term & sclk_q;
  assign sclk     = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!active) begin
      div_q  <= '0;
      sclk_q <= 1'b0;
    end else if (term) begin
      div_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/mcp_shifter.sv
module mcp_shifter
  import mcp_pkg::*;
#(
  parameter int REG_W = EXT_LEN,
  parameter int CW    = CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_start,
  input  logic [REG_W-1:0] load_word,
  input  logic             shift_in,
  input  logic             shift_out,
  input  logic             tx_bit,
  output logic [REG_W-1:0] shreg,
  output logic [CW-1:0]    bit_cnt
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (start) begin
      shreg   <= rd_start ? load_word : '0;
      bit_cnt <= '0;
    end else if (shift_in) begin
      shreg   <= {shreg[REG_W-2:0], tx_bit};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end else if (shift_out) begin
      shreg   <= {shreg[REG_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/mcp_cfg_store.sv
module mcp_cfg_store
  import mcp_pkg::*;
#(
  parameter int                 REG_W    = EXT_LEN,
  parameter int                 LOW_W    = NORM_LEN,
  parameter logic [REG_W-1:0]   DEF_WORD = RESET_WORD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             commit_full,
  input  logic [REG_W-1:0] new_word,
  output logic [REG_W-1:0] cfg_word,
  output cfg_fields_t      fields
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_word <= DEF_WORD;
    end else if (commit) begin
      if (commit_full) cfg_word <= new_word;
      else             cfg_word[LOW_W-1:0] <= new_word[LOW_W-1:0];
    end
  end

  assign fields = decode_cfg(cfg_word);
endmodule

// File: rtl/modem_cfg_port.sv
module modem_cfg_port
  import mcp_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                async_mode,
  input  logic                reg_sel,
  input  logic                rx_tx,
  input  logic                tx_bit,
  output logic                sclk,
  output logic                rx_bit,
  output logic [EXT_LEN-1:0]  cfg_word,
  output logic [1:0]          baud_code,
  output logic [RATE_W-1:0]   baud_rate,
  output logic [RATE_W-1:0]   dev_hz,
  output logic                wdog_en,
  output logic                ext_en,
  output logic                long_rd
);
  localparam int PAD_W = EXT_LEN - NORM_LEN;
  localparam logic [CNT_W-1:0] LEN_N = CNT_W'(NORM_LEN);
  localparam logic [CNT_W-1:0] LEN_E = CNT_W'(EXT_LEN);

  logic               active, active_q, start, finish, rd_q;
  logic               rise_evt, fall_evt, commit, read_long;
  logic [EXT_LEN-1:0] shreg, load_word;
  logic [CNT_W-1:0]   bit_cnt, need_cnt;
  cfg_fields_t        fields;

  assign active = reg_sel & ~async_mode;
  assign start  = active & ~active_q;
  assign finish = active_q & ~active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      rd_q     <= 1'b0;
    end else begin
      active_q <= active;
      if (start) rd_q <= rx_tx;
    end
  end

  mcp_sclk_gen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .sclk     (sclk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  assign read_long = fields.ext_en & fields.long_rd;
  assign load_word = read_long ? cfg_word : {cfg_word[NORM_LEN-1:0], {PAD_W{1'b0}}};

  mcp_shifter #(.REG_W(EXT_LEN), .CW(CNT_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rd_start  (rx_tx),
    .load_word (load_word),
    .shift_in  (rise_evt & ~rd_q),
    .shift_out (fall_evt & rd_q),
    .tx_bit    (tx_bit),
    .shreg     (shreg),
    .bit_cnt   (bit_cnt)
  );

  assign need_cnt = fields.ext_en ? LEN_E : LEN_N;
  assign commit   = finish & ~rd_q & ~async_mode & (bit_cnt == need_cnt);

  mcp_cfg_store #(.REG_W(EXT_LEN), .LOW_W(NORM_LEN), .DEF_WORD(RESET_WORD)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .commit_full (fields.ext_en),
    .new_word    (shreg),
    .cfg_word    (cfg_word),
    .fields      (fields)
  );

  assign rx_bit    = active_q & rd_q & shreg[EXT_LEN-1];
  assign baud_code = fields.baud_code;
  assign baud_rate = fields.baud_rate;
  assign dev_hz    = fields.dev_hz;
  assign wdog_en   = fields.wdog_en;
  assign ext_en    = fields.ext_en;
  assign long_rd   = fields.long_rd;
endmodule

// File: rtl/mcp_checker.sv
module mcp_checker
  import mcp_pkg::*;
#(
  parameter int DIV_HALF = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_sel,
  input logic               async_mode,
  input logic               sclk,
  input logic               rx_bit,
  input logic [EXT_LEN-1:0] cfg_word,
  input logic [RATE_W-1:0]  baud_rate,
  input logic [RATE_W-1:0]  dev_hz
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_sel || async_mode) |=> !sclk); // R2

  AST_ASYNC_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_word) |-> ($past(!reg_sel) && $past(!async_mode))); // R8

  AST_RX_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(rx_bit)); // R6

  AST_RX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_sel |=> !rx_bit); // R6

  AST_DEV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_hz <= baud_rate) && (dev_hz >= 13'd300)); // R9

  generate
    if (DIV_HALF > 1) begin : g_hold
      AST_SCLK_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |=> sclk); // R2
      AST_SCLK_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |=> !sclk); // R2
    end
  endgenerate
endmodule

bind modem_cfg_port mcp_checker #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_sel    (reg_sel),
  .async_mode (async_mode),
  .sclk       (sclk),
  .rx_bit     (rx_bit),
  .cfg_word   (cfg_word),
  .baud_rate  (baud_rate),
  .dev_hz     (dev_hz)
);

// File: tb/sim_modem_cfg_port.sv
module sim_modem_cfg_port;
  localparam int DIV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic async_mode = 1'b0, reg_sel = 1'b0, rx_tx = 1'b0, tx_bit = 1'b0;
  logic sclk, rx_bit, wdog_en, ext_en, long_rd;
  logic [47:0] cfg_word;
  logic [1:0]  baud_code;
  logic [12:0] baud_rate, dev_hz;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  modem_cfg_port #(.DIV_HALF(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .async_mode(async_mode), .reg_sel(reg_sel),
    .rx_tx(rx_tx), .tx_bit(tx_bit), .sclk(sclk), .rx_bit(rx_bit),
    .cfg_word(cfg_word), .baud_code(baud_code), .baud_rate(baud_rate),
    .dev_hz(dev_hz), .wdog_en(wdog_en), .ext_en(ext_en), .long_rd(long_rd)
  );

  // {24-bit word, baud, deviation, watchdog}; bits 21 and 18 clear
  localparam logic [63:0] VEC [4] = '{
    {24'h000000, 16'd600,  16'd300,  8'd0},
    {24'h0A5A2B, 16'd1200, 16'd1200, 8'd0},
    {24'hC0005F, 16'd4800, 16'd2400, 8'd1},
    {24'h913370, 16'd2400, 16'd2400, 8'd1}
  };

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_rise;
    while (sclk !== 1'b1) @(negedge clk);
  endtask

  task automatic wait_fall;
    while (sclk !== 1'b0) @(negedge clk);
  endtask

  task automatic do_write(input int n, input logic [47:0] data, input bit flip);
    @(negedge clk);
    rx_tx   = 1'b0;
    tx_bit  = data[n-1];
    reg_sel = 1'b1;
    for (int i = n - 1; i >= 0; i--) begin
      tx_bit = data[i];
      wait_rise();
      if (flip) rx_tx = 1'b1;
      wait_fall();
    end
    reg_sel = 1'b0;
    rx_tx   = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_read(input int n, output logic [47:0] data, output logic extra);
    data = '0;
    @(negedge clk);
    rx_tx   = 1'b1;
    reg_sel = 1'b1;
    for (int i = n - 1; i >= 0; i--) begin
      wait_rise();
      data[i] = rx_bit;
      wait_fall();
    end
    wait_rise();
    extra = rx_bit;
    wait_fall();
    reg_sel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [47:0] rd;
    logic        ex;
    int          gap;
    bit          seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cfg_word", cfg_word, 48'h50);
    check("R1 sclk", {47'd0, sclk}, 48'd0);
    check("R1 rx_bit", {47'd0, rx_bit}, 48'd0);
    check("R1 baud", {35'd0, baud_rate}, 48'd2400);
    check("R1 dev", {35'd0, dev_hz}, 48'd1200);
    check("R1 wdog", {47'd0, wdog_en}, 48'd1);

    // R3 R9 R6 vector walk
    foreach (VEC[k]) begin
      do_write(24, {24'd0, VEC[k][63:40]}, 1'b0);
      check("R3 write", cfg_word, {24'd0, VEC[k][63:40]});
      check("R9 baud", {35'd0, baud_rate}, {32'd0, VEC[k][39:24]});
      check("R9 dev", {35'd0, dev_hz}, {32'd0, VEC[k][23:8]});
      check("R9 wdog", {47'd0, wdog_en}, {47'd0, VEC[k][0]});
      do_read(24, rd, ex);
      check("R6 read", rd, {24'd0, VEC[k][63:40]});
      check("R6 after last", {47'd0, ex}, 48'd0);
    end

    // R5 wrong counts
    do_write(23, 48'h000123, 1'b0);
    check("R5 short", cfg_word, 48'h913370);
    do_write(25, 48'h1000123, 1'b0);
    check("R5 long", cfg_word, 48'h913370);

    // R8 async lockout
    @(negedge clk);
    async_mode = 1'b1;
    reg_sel = 1'b1;
    seen = 1'b0;
    for (int i = 0; i < 40; i++) begin
      tx_bit = i[0];
      @(negedge clk);
      if (sclk) seen = 1'b1;
    end
    reg_sel = 1'b0;
    @(negedge clk);
    async_mode = 1'b0;
    check("R8 no sclk", {47'd0, seen}, 48'd0);
    check("R8 cfg kept", cfg_word, 48'h913370);

    // R2 period
    @(negedge clk);
    rx_tx = 1'b1;
    reg_sel = 1'b1;
    wait_rise();
    wait_fall();
    gap = 0;
    while (sclk !== 1'b1) begin @(negedge clk); gap++; end
    wait_fall();
    reg_sel = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 half period", 48'(gap), 48'(DIV));
    check("R2 idle low", {47'd0, sclk}, 48'd0);

    // R10 direction latched
    do_write(24, 48'h0A5A2B, 1'b1);
    check("R10 latched write", cfg_word, 48'h0A5A2B);

    // R7 extended without long read
    do_write(24, 48'h200050, 1'b0);
    check("R7 ext on", {47'd0, ext_en}, 48'd1);
    do_read(24, rd, ex);
    check("R7 short read", rd, 48'h200050);
    check("R7 short read end", {47'd0, ex}, 48'd0);
    // R4 48-bit write
    do_write(48, 48'hABCDEF_240077, 1'b0);
    check("R4 full write", cfg_word, 48'hABCDEF_240077);
    do_read(48, rd, ex);
    check("R7 long read", rd, 48'hABCDEF_240077);
    check("R7 long read end", {47'd0, ex}, 48'd0);
    do_write(24, 48'h000000, 1'b0);
    check("R4 24 in ext discarded", cfg_word, 48'hABCDEF_240077);
    do_write(48, 48'h123456_000050, 1'b0);
    check("R4 leave ext", cfg_word, 48'h123456_000050);
    // R3 upper preserved
    do_write(24, 48'h00005F, 1'b0);
    check("R3 upper kept", cfg_word, 48'h123456_00005F);
    do_read(24, rd, ex);
    check("R6 low read", rd, 48'h00005F);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule